// File: doc/BRIEF.md
# Bus Fault Status Capture

This block records what went wrong when the memory access checker rejects a CPU transfer. When the checker raises its fault strobe, the block loads a 16-bit general status word with a fixed code chosen by the fault kind and the transfer direction. It also loads two 16-bit bus status words. The first holds the transfer width, the byte lane and the top address byte. The second holds the low sixteen address bits. One cycle later it sends a single-cycle bus-error pulse to the CPU.

Software reads the three words through a small register port. Each read returns the selected 16-bit word copied into both halves of a 32-bit bus. A write of any data to the clear location sets all three words back to all ones. The block does not interpret the individual status bits and does not route interrupts.

Top module: `bus_fault_capture`

## Requirements
- R1: After reset, the general status word and both bus status words read as 0xFFFF, and the bus-error output is low.
- R2: A fault of kind 0 (page not present) loads the general status word with 0x8BFF for a write (`flt_wr`=1) and 0xCBFF for a read.
- R3: A fault of kind 1 (user access outside RAM) loads the general status word with 0x9AFF for a write and 0xDAFF for a read.
- R4: When `par_ie` is 1 during a kind 0 or kind 1 fault, bit 10 (0x0400) is also set in the loaded general status value.
- R5: A fault of kind 2 (user access to kernel space) or kind 3 (write to a protected page) leaves the general status word unchanged. It still loads both bus status words and still raises the bus error.
- R6: On any fault, bus status word 0 gets an upper byte of 0x7C when `flt_size` is 1 (16-bit) or 2 or 3 (32-bit). When `flt_size` is 0 (byte), the upper byte is 0x7D for an odd address and 0x7E for an even address. Its lower byte is fault address bits [23:16].
- R7: On any fault, bus status word 1 is loaded with fault address bits [15:0].
- R8: `berr_o` is high for exactly the one cycle after each clock edge at which `flt_stb` was high. Strobes on back-to-back cycles give consecutive high cycles.
- R9: A register write (`reg_wr`=1) to `reg_addr`=3 sets all three words to 0xFFFF, whatever the write data. Writes to `reg_addr` 0, 1 and 2 change nothing.
- R10: `reg_rdata` holds the word selected by `reg_addr` in both 16-bit halves. Address 0 selects general status, 1 selects bus status 0, 2 selects bus status 1, and 3 reads as 0xFFFFFFFF.
- R11: When a fault strobe and a clear write arrive in the same cycle, the fault is captured and the clear is ignored.
- R12: With no fault strobe and no clear write, all three words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_stb | input | 1 | Fault reported in this cycle |
| flt_kind | input | 2 | Fault kind: 0 page, 1 user outside RAM, 2 kernel, 3 write-protect |
| flt_wr | input | 1 | Faulting transfer was a write |
| flt_size | input | 2 | Transfer width: 0 byte, 1 16-bit, 2/3 32-bit |
| flt_addr | input | 24 | Faulting address |
| par_ie | input | 1 | Parity interrupt enable, folded into the status code |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data (ignored) |
| reg_rdata | output | 32 | Selected word, duplicated in both halves |
| berr_o | output | 1 | Bus-error pulse to the CPU |

## Verification
The bench builds the block with its default 24-bit address and 16-bit words. At these values every code, lane tag and address split the requirements name can be compared exactly against a behavioural model. It steps through all four fault kinds in both directions, with and without parity enable, and across byte, 16-bit and 32-bit widths at odd and even addresses. Back-to-back strobes, a fault that coincides with a clear, and ignored writes to the status locations are also covered.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        FK_PAGE  = 2'd0,
        FK_UIO   = 2'd1,
        FK_KERN  = 2'd2,
        FK_WPROT = 2'd3
    } flt_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LNG2 = 2'd3
    } flt_size_e;

    typedef enum logic [1:0] {
        SEL_GSR = 2'd0,
        SEL_BS0 = 2'd1,
        SEL_BS1 = 2'd2,
        SEL_CLR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] gsr;
        logic [WORD_W-1:0] bs0;
        logic [WORD_W-1:0] bs1;
        logic              berr;
    } cap_state_t;
endpackage

// File: rtl/bfc_code_enc.sv
module bfc_code_enc
    import bfc_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  flt_kind_e       kind,
    input  logic            wr,
    input  logic            par_ie,
    output logic            load,
    output logic [W-1:0]    code
);
    localparam logic [W-1:0] PIE_BIT = W'(16'h0400);

    logic [W-1:0] base;

    always_comb begin
        load = 1'b0;
        base = '1;
        case (kind)
            FK_PAGE: begin
                load = 1'b1;
                base = wr ? W'(16'h8BFF) : W'(16'hCBFF);
            end
            FK_UIO: begin
                load = 1'b1;
                base = wr ? W'(16'h9AFF) : W'(16'hDAFF);
            end
            default: begin
                load = 1'b0;
                base = '1;
            end
        endcase
        code = base | (par_ie ? PIE_BIT : '0);
    end
endmodule

// File: rtl/bfc_lane_enc.sv
module bfc_lane_enc
    import bfc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int W      = WORD_W
) (
    input  flt_size_e         size,
    input  logic [ADDR_W-1:0] addr,
    output logic [W-1:0]      bs0,
    output logic [W-1:0]      bs1
);
    localparam int TAG_W = W / 2;
    localparam int HI_W  = ADDR_W - W;

    logic [TAG_W-1:0] tag;

    always_comb begin
        if (size == SZ_BYTE)
            tag = addr[0] ? TAG_W'(8'h7D) : TAG_W'(8'h7E);
        else
            tag = TAG_W'(8'h7C);
        bs0 = {tag, addr[ADDR_W-1 -: HI_W]};
        bs1 = addr[W-1:0];
    end
endmodule

// File: rtl/bfc_rd_mux.sv
module bfc_rd_mux
    import bfc_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int LANES = 2
) (
    input  reg_sel_e           sel,
    input  logic [W-1:0]       gsr,
    input  logic [W-1:0]       bs0,
    input  logic [W-1:0]       bs1,
    output logic [LANES*W-1:0] rdata
);
    logic [W-1:0] word;

    always_comb begin
        case (sel)
            SEL_GSR: word = gsr;
            SEL_BS0: word = bs0;
            SEL_BS1: word = bs1;
            default: word = '1;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*W +: W] = word;
    end
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
    import bfc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flt_stb,
    input  logic [1:0]              flt_kind,
    input  logic                    flt_wr,
    input  logic [1:0]              flt_size,
    input  logic [ADDR_W-1:0]       flt_addr,
    input  logic                    par_ie,
    input  logic [1:0]              reg_addr,
    input  logic                    reg_wr,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [LANES*WORD_W-1:0] reg_rdata,
    output logic                    berr_o
);
    localparam int W = WORD_W;

    cap_state_t st_d, st_q;

    logic         gsr_load;
    logic [W-1:0] gsr_code;
    logic [W-1:0] bs0_val;
    logic [W-1:0] bs1_val;
    logic         clr_hit;
    logic         wdata_unused;

    assign wdata_unused = ^reg_wdata;

    bfc_code_enc #(.W(W)) u_code (
        .kind   (flt_kind_e'(flt_kind)),
        .wr     (flt_wr),
        .par_ie (par_ie),
        .load   (gsr_load),
        .code   (gsr_code)
    );

    bfc_lane_enc #(.ADDR_W(ADDR_W), .W(W)) u_lane (
        .size (flt_size_e'(flt_size)),
        .addr (flt_addr),
        .bs0  (bs0_val),
        .bs1  (bs1_val)
    );

    bfc_rd_mux #(.W(W), .LANES(LANES)) u_rd (
        .sel   (reg_sel_e'(reg_addr)),
        .gsr   (st_q.gsr),
        .bs0   (st_q.bs0),
        .bs1   (st_q.bs1),
        .rdata (reg_rdata)
    );

    assign clr_hit = reg_wr && (reg_sel_e'(reg_addr) == SEL_CLR);

    always_comb begin
        st_d      = st_q;
        st_d.berr = flt_stb;
        if (flt_stb) begin
            st_d.bs0 = bs0_val;
            st_d.bs1 = bs1_val;
            if (gsr_load)
                st_d.gsr = gsr_code;
        end else if (clr_hit) begin
            st_d.gsr = '1;
            st_d.bs0 = '1;
            st_d.bs1 = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gsr  <= '1;
            st_q.bs0  <= '1;
            st_q.bs1  <= '1;
            st_q.berr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign berr_o = st_q.berr;

    // R8
    berr_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> berr_o);

    // R8
    berr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_stb |=> !berr_o);

    // R7
    bs1_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (st_q.bs1 == $past(flt_addr[W-1:0])));

    // R9
    clear_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3 && !flt_stb) |=>
            (st_q.gsr == '1 && st_q.bs0 == '1 && st_q.bs1 == '1));

    // R5
    kern_keeps_gsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && flt_kind[1]) |=> $stable(st_q.gsr));

    // R12
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_stb && !(reg_wr && reg_addr == 2'd3)) |=>
            (st_q.gsr == $past(st_q.gsr) && st_q.bs0 == $past(st_q.bs0)
             && st_q.bs1 == $past(st_q.bs1)));

    // R10
    dup_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[LANES*W-1 -: W] == reg_rdata[W-1:0]);
endmodule

// File: tb/sim_bus_fault_capture.sv
module sim_bus_fault_capture;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_stb = 1'b0;
    logic [1:0]  flt_kind = '0;
    logic        flt_wr = 1'b0;
    logic [1:0]  flt_size = '0;
    logic [23:0] flt_addr = '0;
    logic        par_ie = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        berr_o;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    int m_gsr = 'hFFFF;
    int m_bs0 = 'hFFFF;
    int m_bs1 = 'hFFFF;
    int m_berr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_fault_capture u0 (
        .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_kind(flt_kind),
        .flt_wr(flt_wr), .flt_size(flt_size), .flt_addr(flt_addr),
        .par_ie(par_ie), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .berr_o(berr_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WDOG_LIMIT && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected < %0d", cycles, WDOG_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int gsr_code(int kind, int wr, int pie);
        int v;
        if (kind == 0) v = wr ? 'h8BFF : 'hCBFF;
        else           v = wr ? 'h9AFF : 'hDAFF;
        if (pie != 0) v = v | 'h0400;
        return v;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_gsr = 'hFFFF; m_bs0 = 'hFFFF; m_bs1 = 'hFFFF; m_berr = 0;
        end else begin
            m_berr = flt_stb;
            if (flt_stb) begin
                int tag;
                if (flt_size == 0) tag = flt_addr[0] ? 'h7D : 'h7E;
                else tag = 'h7C;
                m_bs0 = (tag * 256) + int'(flt_addr[23:16]);
                m_bs1 = int'(flt_addr[15:0]);
                if (flt_kind < 2) m_gsr = gsr_code(flt_kind, flt_wr, par_ie);
            end else if (reg_wr && reg_addr == 2'd3) begin
                m_gsr = 'hFFFF; m_bs0 = 'hFFFF; m_bs1 = 'hFFFF;
            end
        end
    endtask

    task automatic cyc(string tag);
        logic [31:0] exp_rd;
        int w;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        case (reg_addr)
            2'd0: w = m_gsr;
            2'd1: w = m_bs0;
            2'd2: w = m_bs1;
            default: w = -1;
        endcase
        exp_rd = (reg_addr == 2'd3) ? 32'hFFFF_FFFF : {w[15:0], w[15:0]};
        n_tests++;
        if (reg_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s: reg_rdata sel=%0d actual=%h expected=%h", tag, reg_addr, reg_rdata, exp_rd);
        end
        n_tests++;
        if (berr_o !== m_berr[0]) begin
            n_fail++;
            $display("FAIL R8 (%s): berr_o actual=%b expected=%b", tag, berr_o, m_berr[0]);
        end
    endtask

    task automatic read_all(string tag);
        for (int s = 0; s < 4; s++) begin
            reg_addr = 2'(s);
            cyc(tag);
        end
    endtask

    task automatic fault(int kind, int wr, int size, int addr, int pie, string tag);
        flt_stb = 1'b1; flt_kind = 2'(kind); flt_wr = wr[0];
        flt_size = 2'(size); flt_addr = 24'(addr); par_ie = pie[0];
        cyc(tag);
        flt_stb = 1'b0;
        read_all(tag);
    endtask

    task automatic clear(int data, string tag);
        reg_addr = 2'd3; reg_wr = 1'b1; reg_wdata = 16'(data);
        cyc(tag);
        reg_wr = 1'b0;
        read_all(tag);
    endtask

    initial begin
        // R1: reset state
        repeat (3) cyc("R1");
        rst_n = 1'b1;
        read_all("R1");

        // R2: page fault codes, write then read
        fault(0, 1, 1, 'h12_3456, 0, "R2");
        fault(0, 0, 2, 'h3F_FFFE, 0, "R2");
        // R3: user outside RAM codes
        fault(1, 1, 1, 'h40_0010, 0, "R3");
        fault(1, 0, 2, 'hC1_2340, 0, "R3");
        // R4: parity enable folds bit 10
        fault(1, 0, 1, 'h45_6788, 1, "R4");
        fault(0, 1, 0, 'h00_0101, 1, "R4");
        // R5: kernel and write-protect keep general status
        fault(2, 0, 1, 'h07_A000, 1, "R5");
        fault(3, 1, 0, 'h21_0003, 0, "R5");
        // R6: lane tags
        fault(3, 1, 0, 'hAB_CDEF, 0, "R6");
        fault(2, 1, 0, 'h5A_5A5A, 0, "R6");
        fault(3, 0, 3, 'hFF_0001, 0, "R6");
        // R7: address split patterns
        fault(0, 0, 1, 'h00_0000, 0, "R7");
        fault(1, 1, 1, 'hFF_FFFE, 0, "R7");

        // R8: back-to-back strobes
        flt_stb = 1'b1; flt_kind = 2'd0; flt_wr = 1'b0; flt_size = 2'd1;
        flt_addr = 24'h11_2222; par_ie = 1'b0; reg_addr = 2'd2;
        cyc("R8");
        flt_addr = 24'h33_4444; flt_kind = 2'd1;
        cyc("R8");
        flt_stb = 1'b0;
        cyc("R8");
        read_all("R8");

        // R9: clear with arbitrary data, then writes to other locations ignored
        clear('h1234, "R9");
        fault(0, 1, 1, 'h0A_0B0C, 1, "R9");
        for (int s = 0; s < 3; s++) begin
            reg_addr = 2'(s); reg_wr = 1'b1; reg_wdata = 16'h0000;
            cyc("R9");
        end
        reg_wr = 1'b0;
        read_all("R9");
        clear('h0000, "R9");

        // R10: duplication and clear location readback
        fault(1, 0, 0, 'h9C_8D7F, 1, "R10");
        reg_addr = 2'd3;
        cyc("R10");

        // R11: fault and clear in the same cycle
        flt_stb = 1'b1; flt_kind = 2'd0; flt_wr = 1'b1; flt_size = 2'd2;
        flt_addr = 24'h2B_C0DE; par_ie = 1'b0;
        reg_addr = 2'd3; reg_wr = 1'b1; reg_wdata = 16'hFFFF;
        cyc("R11");
        flt_stb = 1'b0; reg_wr = 1'b0;
        read_all("R11");
        flt_stb = 1'b1; flt_kind = 2'd2; flt_addr = 24'h01_0201;
        reg_addr = 2'd3; reg_wr = 1'b1;
        cyc("R11");
        flt_stb = 1'b0; reg_wr = 1'b0;
        read_all("R11");

        // R12: hold with changing fault inputs but no strobe
        flt_kind = 2'd1; flt_addr = 24'hFE_DCBA; par_ie = 1'b1; flt_size = 2'd0;
        for (int k = 0; k < 3; k++) read_all("R12");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule